// File: doc/BRIEF.md
# Divided-Clock One-Shot Countdown Timer

This block is the countdown timer of an interrupt controller. Software programs a divide setting and then writes a start count. The write arms a single countdown that lasts the count multiplied by the divisor, measured in timer ticks. A tick is a one-cycle strobe on `tick_i`; if the strobe is tied high, every clock is a tick. When the countdown ends, the block raises `expire_o` for exactly one clock and goes idle. The interrupt that follows from that pulse is raised by neighbouring logic.

While the countdown runs, software can read a remaining-count register. It reports the time left in whole divided periods, and a partial period counts as a full one. The block also holds the timer's vector-table entry. Software writes every bit of that entry except two status bits, which always reflect `lvt_sts_i` as driven by the delivery logic.

A write to the start-count register can arrive in a cycle without a tick, that is, between tick edges. The countdown then first waits for the next tick to align itself, so expiry comes one tick later than it would otherwise.

Top module: `divclk_oneshot_timer`

## Requirements
- R1: The divisor is 2 raised to ((({cfg[3],cfg[1:0]}) + 1) mod 8). Setting 0b1011 gives 1, 0b0000 gives 2 and 0b1010 gives 128.
- R2: The divide-setting register at offset 0x3E0 keeps only bits 3, 1 and 0 of a write. All other bits read back as 0.
- R3: A write to the start-count register at offset 0x380 with a nonzero value N restarts the countdown from N, discarding any countdown already running. When the write clock has `tick_i` high, `expire_o` rises after the N*D-th later tick edge, where D is the divisor.
- R4: When the start write lands in a clock with `tick_i` low, the first later tick only aligns the countdown. `expire_o` then rises after the (N*D+1)-th later tick edge.
- R5: The remaining-count register at offset 0x390 reads ceil(T/D), where T is the number of ticks still needed before expiry. It reads 0 while idle.
- R6: Writes to offset 0x390 change neither the countdown nor any register.
- R7: The vector-table entry at offset 0x320 stores all written bits except bits 12 and 14. Those two bits read as `lvt_sts_i[0]` and `lvt_sts_i[1]`.
- R8: Writing 0 to the start-count register stops the countdown at once, and no `expire_o` pulse follows.
- R9: `expire_o` is high for exactly one clock. After that the remaining count reads 0, and the start-count register still reads the last value written to it.
- R10: Reads of any address other than the four offsets return 0, and writes to them have no effect.
- R11: After reset all registers read 0 (with `lvt_sts_i` low) and `expire_o` is low. Reset is asynchronous, and its release passes through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer time-base strobe, one tick per high clock |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| lvt_sts_i | input | 2 | Status bits shown at entry bits 12 and 14 |
| expire_o | output | 1 | One-clock pulse when the countdown ends |

## Verification
A wrong prescaler value or a lost alignment flag shows up as an expiry that comes early or late, by a whole number of ticks. It also shows in the remaining count, which steps at the wrong tick, and that difference can be read within one divided period of the start. A wrongly decoded divide setting scales every expiry by a power of two. The bench therefore sweeps all eight divisor codes with several start counts. Corruption of the stored count or of the idle flag shows as a remaining count that is nonzero after the pulse, or as a pulse that follows a stop.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;
  localparam int OFS_W   = 12;

  localparam logic [OFS_W-1:0] OFS_VEC  = 12'h320;
  localparam logic [OFS_W-1:0] OFS_LOAD = 12'h380;
  localparam logic [OFS_W-1:0] OFS_LEFT = 12'h390;
  localparam logic [OFS_W-1:0] OFS_DIV  = 12'h3E0;

  localparam int VEC_STS0_BIT = 12;
  localparam int VEC_STS1_BIT = 14;

  // divide code is {cfg[3], cfg[1:0]}; shift wraps modulo 8
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SHIFT_W-1:0] code);
    return code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/dtmr_divdec.sv
module dtmr_divdec
  import dtmr_pkg::*;
(
  input  logic [SHIFT_W-1:0] code_i,
  output logic [PRE_W-1:0]   div_m1_o
);
  logic [SHIFT_W-1:0] sh;
  logic [PRE_W:0]     pow2;
  logic [PRE_W:0]     pow2_m1;

  always_comb begin
    sh       = div_shift(code_i);
    pow2     = (PRE_W+1)'(1) << sh;
    pow2_m1  = pow2 - (PRE_W+1)'(1);
    div_m1_o = pow2_m1[PRE_W-1:0];
  end
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [1:0]         sts_i,
  input  logic [CNT_W-1:0]   left_i,
  output logic [SHIFT_W-1:0] code_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   load_val_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [DATA_W-1:0] STS_MASK =
    (DATA_W'(1) << VEC_STS0_BIT) | (DATA_W'(1) << VEC_STS1_BIT);

  logic sel_vec, sel_load, sel_left, sel_div;
  logic en_vec, en_load, en_div;

  logic [DATA_W-1:0]  vec_q, vec_d;
  logic [CNT_W-1:0]   load_q, load_d;
  logic [SHIFT_W-1:0] code_q, code_d;

  always_comb begin
    sel_vec  = (addr_i == ADDR_W'(OFS_VEC));
    sel_load = (addr_i == ADDR_W'(OFS_LOAD));
    sel_left = (addr_i == ADDR_W'(OFS_LEFT));
    sel_div  = (addr_i == ADDR_W'(OFS_DIV));
    en_vec   = wr_i & sel_vec;
    en_load  = wr_i & sel_load;
    en_div   = wr_i & sel_div;
    vec_d    = wdata_i & ~STS_MASK;
    load_d   = wdata_i[CNT_W-1:0];
    code_d   = {wdata_i[3], wdata_i[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      load_q <= '0;
      code_q <= '0;
    end else begin
      if (en_vec)  vec_q  <= vec_d;
      if (en_load) load_q <= load_d;
      if (en_div)  code_q <= code_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_vec) begin
      rdata_o = vec_q;
      rdata_o[VEC_STS0_BIT] = sts_i[0];
      rdata_o[VEC_STS1_BIT] = sts_i[1];
    end else if (sel_load) begin
      rdata_o = DATA_W'(load_q);
    end else if (sel_left) begin
      rdata_o = DATA_W'(left_i);
    end else if (sel_div) begin
      rdata_o = DATA_W'({code_q[2], 1'b0, code_q[1:0]});
    end
  end

  assign code_o     = code_q;
  assign load_o     = en_load;
  assign load_val_o = load_d;

  AST_LEFT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_left) |=> ($stable(vec_q) && $stable(load_q) && $stable(code_q))); // R6
  AST_VEC_STS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_q & STS_MASK) == '0)); // R7
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(sel_vec || sel_load || sel_left || sel_div))
      |=> ($stable(vec_q) && $stable(load_q) && $stable(code_q))); // R10
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [PRE_W-1:0] div_m1_i,
  output logic [CNT_W-1:0] left_o,
  output logic             expire_o
);
  logic             act_q, act_d;
  logic             pend_q, pend_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             en;

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    exp_d  = 1'b0;
    en     = load_i | (act_q & tick_i);
    if (load_i) begin
      if (load_val_i == '0) begin
        act_d  = 1'b0;
        pend_d = 1'b0;
        pre_d  = '0;
        cnt_d  = '0;
      end else begin
        act_d  = 1'b1;
        pend_d = ~tick_i;
        pre_d  = div_m1_i;
        cnt_d  = load_val_i;
      end
    end else if (act_q && tick_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else if (pre_q != '0) begin
        pre_d = pre_q - PRE_W'(1);
      end else if (cnt_q == CNT_W'(1)) begin
        act_d = 1'b0;
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        pre_d = div_m1_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= exp_d;
      if (en) begin
        act_q  <= act_d;
        pend_q <= pend_d;
        pre_q  <= pre_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  // a pending alignment tick adds one partial period to the rounded count
  assign left_o   = (pend_q && !(&cnt_q)) ? cnt_q + CNT_W'(1) : cnt_q;
  assign expire_o = exp_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q); // R9
  AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> (!act_q && cnt_q == '0)); // R9
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i != '0) |=> (act_q && cnt_q == $past(load_val_i))); // R3
  AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> (!act_q && !exp_q)); // R8
  AST_LEFT_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load_i) |=> (cnt_q <= $past(cnt_q))); // R5
  AST_ALIGN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> act_q); // R4
endmodule

// File: rtl/divclk_oneshot_timer.sv
module divclk_oneshot_timer
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        lvt_sts_i,
  output logic              expire_o
);
  logic [1:0]         rs_q;
  logic               rst_sync_n;
  logic [SHIFT_W-1:0] code;
  logic [PRE_W-1:0]   div_m1;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic [CNT_W-1:0]   left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  dtmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr_i     (bus_addr),
    .wr_i       (bus_wr),
    .wdata_i    (bus_wdata),
    .sts_i      (lvt_sts_i),
    .left_i     (left),
    .code_o     (code),
    .load_o     (load),
    .load_val_o (load_val),
    .rdata_o    (bus_rdata)
  );

  dtmr_divdec u_divdec (
    .code_i   (code),
    .div_m1_o (div_m1)
  );

  dtmr_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .div_m1_i   (div_m1),
    .left_o     (left),
    .expire_o   (expire_o)
  );

  AST_NO_PULSE_IN_RESET: assert property (@(posedge clk)
    !rst_sync_n |-> !expire_o); // R11
endmodule

// File: tb/divclk_oneshot_timer_tb.sv
module divclk_oneshot_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_VEC = 12'h320, A_LOAD = 12'h380, A_LEFT = 12'h390, A_DIV = 12'h3E0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [11:0] addr = '0;
  logic wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0] sts = 2'b00;
  logic expire;

  int tests = 0;
  int fails = 0;
  int tick_per = 0;
  int ph = 0;
  logic w_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tick_per <= 1) tick <= 1'b1;
    else begin
      ph = (ph + 1) % tick_per;
      tick <= (ph == 0);
    end
  end

  divclk_oneshot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .lvt_sts_i(sts), .expire_o(expire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge; write edge in between
  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    w_tick = tick;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_exp(input int lim, output int cyc, output int tk);
    cyc = -1; tk = 0;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      if (tick) tk++;
      @(negedge clk);
      if (expire) begin cyc = i; break; end
    end
  endtask

  function automatic int exp_div(input int c);
    int s;
    s = (((c >> 3) & 1) << 2) | (c & 3);
    s = (s + 1) % 8;
    return 1 << s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc, tk, d, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 expire", {31'b0, expire}, 32'h0);
    rreg(A_VEC, v);  chk("R11 vec", v, 32'h0);
    rreg(A_LOAD, v); chk("R11 load", v, 32'h0);
    rreg(A_LEFT, v); chk("R11 left", v, 32'h0);
    rreg(A_DIV, v);  chk("R11 div", v, 32'h0);

    // R2 divide-setting masking, all low nibbles
    for (int c = 0; c < 16; c++) begin
      wreg(A_DIV, 32'hFFFF_FFF0 | c);
      rreg(A_DIV, v);
      chk("R2 div mask", v, c & 32'hB);
    end

    // R1 R3 R9 sweep: every divisor code, counts 1..3, tick every clock
    for (int c = 0; c < 16; c++) begin
      if ((c & 4) != 0) continue;
      d = exp_div(c);
      for (int nn = 1; nn <= 3; nn++) begin
        wreg(A_DIV, c);
        wreg(A_LOAD, nn);
        wait_exp(400, cyc, tk);
        chk("R1 R3 expiry cycles", cyc, nn * d);
        rreg(A_LEFT, v); chk("R9 left after expiry", v, 32'h0);
        rreg(A_LOAD, v); chk("R9 load readback", v, nn);
        @(negedge clk);
        chk("R9 single pulse", {31'b0, expire}, 32'h0);
      end
    end

    // R5 rounded remaining count, D=4 N=3
    wreg(A_DIV, 32'h1);
    wreg(A_LOAD, 3);
    rreg(A_LEFT, v); chk("R5 left k=0", v, 3);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      rreg(A_LEFT, v);
      chk("R5 left", v, (12 - k + 3) / 4);
      if (k == 12) chk("R5 expire at end", {31'b0, expire}, 32'h1);
      else chk("R5 no early expire", {31'b0, expire}, 32'h0);
    end

    // R4 alignment with a tick every third clock, D=2 N=2
    tick_per = 3;
    wreg(A_DIV, 32'h0);
    for (int off = 0; off < 3; off++) begin
      repeat (off + 1) @(negedge clk);
      wreg(A_LOAD, 2);
      if (!w_tick) begin
        rreg(A_LEFT, v); chk("R4 R5 left while aligning", v, 3);
      end
      wait_exp(100, cyc, tk);
      chk("R4 expiry ticks", tk, w_tick ? 4 : 5);
    end
    tick_per = 0;
    repeat (2) @(negedge clk);

    // R6 write to remaining-count register ignored, D=2 N=5
    wreg(A_DIV, 32'h0);
    wreg(A_LOAD, 5);
    repeat (3) @(negedge clk);
    wreg(A_LEFT, 32'h99);
    rreg(A_LEFT, v); chk("R6 left unchanged", v, 3);
    rreg(A_LOAD, v); chk("R6 load unchanged", v, 5);
    rreg(A_DIV, v);  chk("R6 div unchanged", v, 0);
    wait_exp(100, cyc, tk);
    chk("R6 expiry unchanged", cyc, 5);

    // R3 restart while running, D=1
    wreg(A_DIV, 32'hB);
    wreg(A_LOAD, 50);
    repeat (10) @(negedge clk);
    wreg(A_LOAD, 4);
    wait_exp(100, cyc, tk);
    chk("R3 restart expiry", cyc, 4);

    // R8 zero write stops without pulse
    wreg(A_LOAD, 100);
    repeat (5) @(negedge clk);
    wreg(A_LOAD, 0);
    rreg(A_LEFT, v); chk("R8 left after stop", v, 0);
    wait_exp(200, cyc, tk);
    chk("R8 no pulse", cyc, -1);

    // R7 vector entry status bits
    sts = 2'b00;
    wreg(A_VEC, 32'hFFFF_FFFF);
    rreg(A_VEC, v); chk("R7 vec sts low", v, 32'hFFFF_AFFF);
    sts = 2'b01; rreg(A_VEC, v); chk("R7 vec sts0", v, 32'hFFFF_BFFF);
    sts = 2'b10; rreg(A_VEC, v); chk("R7 vec sts1", v, 32'hFFFF_EFFF);
    sts = 2'b11;
    wreg(A_VEC, 32'h0001_2345);
    rreg(A_VEC, v); chk("R7 vec write", v, 32'h0001_7345);
    sts = 2'b00;

    // R10 unmapped offsets
    wreg(12'h300, 32'hDEAD_BEEF);
    rreg(12'h300, v); chk("R10 unmapped read", v, 0);
    rreg(A_VEC, v);  chk("R10 vec intact", v, 32'h0001_2345);
    rreg(A_LOAD, v); chk("R10 load intact", v, 0);
    rreg(A_DIV, v);  chk("R10 div intact", v, 32'hB);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule